// File: doc/BRIEF.md
# BCD Calendar Counter with Snapshot

This block is a real-time clock core. It keeps seconds, minutes, hours, day of month, month, two-digit year and weekday as packed BCD bytes. A one-hertz tick input advances the time. The clock handles month lengths and leap years as it rolls over, and every carry ripples through the fields in a single tick.

Software reaches the core through a byte-wide register port with an address bus, a write strobe and a combinational read path. A control byte holds a run bit and a snapshot request bit. Time addresses never return the live counters. They return shadow latches that load only when software requests a snapshot, so a read of all seven bytes stays coherent even if a rollover occurs partway through. Software sets the time by stopping the clock, writing the live counters directly, and then starting the clock again. A status byte reports whether the clock is running and holds a power-up flag that stays set until software clears it.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the live counters and the shadow latches hold second 0x00, minute 0x00, hour 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. The control byte reads 0x00 and the status byte reads 0x80.
- R2: While the run bit (control address 0x0D, bit 0) is 1, each `tick` pulse advances the seconds in packed BCD, so 0x09 is followed by 0x10. While the run bit is 0, ticks leave every field unchanged.
- R3: Seconds and minutes roll from 0x59 to 0x00 and carry into the next field. Hours roll from 0x23 to 0x00 and carry into the day. The whole carry chain settles on one tick.
- R4: The day rolls to 0x01 and advances the month after day 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 0x30 in months 04, 06, 09 and 11.
- R5: In February the last day is 0x29 when the binary value of the BCD year is divisible by 4, year 00 included, and 0x28 in every other year.
- R6: Month 0x12 rolls to 0x01 and increments the year. Year 0x99 rolls to 0x00.
- R7: The weekday (address 0x06) counts 0 to 6. It advances only when the day rolls over, and it wraps from 6 to 0.
- R8: Reads of addresses 0x00 through 0x06 (second, minute, hour, day, month, year, weekday, in that order) return the shadow latches. Writing 1 to control bit 6 sets that bit. On the next clock edge the shadows copy the live counters and bit 6 returns to 0, so bit 6 reads 1 for exactly one cycle. At all other times the shadows hold their value.
- R9: A write to a time address while the run bit is 0 loads that live counter directly. A write to a time address while the run bit is 1 is ignored.
- R10: Control bit 0 reads back as written, and status bit 1 (address 0x0E) reads the same value.
- R11: Status bit 7 is set by reset and cleared by writing a byte to address 0x0E with bit 7 set. Writing a byte with bit 7 clear leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The bench drives the clock to the edge of each rollover and checks the result after one tick. The cases cover the full carry chain from 23:59:59, the end of 30-day and 31-day months, February in leap years, in year 00 and in a common year, and the end of the century. A wrong month-length table would let day 0x31 appear in a 30-day month. A wrong leap test would skip or invent 29 February. A design that skips the BCD adjustment would show 0x0A as a seconds value.

The bench also reads the shadows after extra ticks and expects the old value, which catches a design whose shadows track the live count. It checks that the request bit falls after a single cycle. It checks that writes during counting are ignored, that ticks while stopped do nothing, and that the power-up flag clears only when bit 7 is written as 1.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h0D,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int NF = 7;
  localparam int TW = 8 * NF;
  localparam logic [TW-1:0] TM_RST = 56'h00_00_01_01_00_00_00;

  logic [TW-1:0] tm_q, tm_nx, sh_q;
  logic run_q, snap_q, pu_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  wire [7:0] sec  = tm_q[7:0];
  wire [7:0] min  = tm_q[15:8];
  wire [7:0] hr   = tm_q[23:16];
  wire [7:0] day  = tm_q[31:24];
  wire [7:0] mon  = tm_q[39:32];
  wire [7:0] yr   = tm_q[47:40];
  wire [7:0] wday = tm_q[55:48];

  wire       step     = tick && run_q;
  wire       wr_ctrl  = wr_en && (addr == CTRL_ADDR);
  wire       wr_stat  = wr_en && (addr == STAT_ADDR);
  wire       wr_time  = wr_en && (addr < ADDR_W'(NF));
  wire [7:0] yr_bin   = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
  wire       leap     = (yr_bin[1:0] == 2'd0);

  logic [7:0] day_max;
  always_comb begin
    case (mon)
      8'h02:                      day_max = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: day_max = 8'h30;
      default:                    day_max = 8'h31;
    endcase
  end

  wire c_s  = step && (sec == 8'h59);
  wire c_m  = c_s && (min == 8'h59);
  wire c_h  = c_m && (hr == 8'h23);
  wire c_d  = c_h && (day == day_max);
  wire c_mo = c_d && (mon == 8'h12);

  always_comb begin
    tm_nx = tm_q;
    if (step) begin
      tm_nx[7:0] = c_s ? 8'h00 : bcd_inc(sec);
      if (c_s)  tm_nx[15:8]  = c_m ? 8'h00 : bcd_inc(min);
      if (c_m)  tm_nx[23:16] = c_h ? 8'h00 : bcd_inc(hr);
      if (c_h) begin
        tm_nx[31:24] = c_d ? 8'h01 : bcd_inc(day);
        tm_nx[55:48] = (wday == 8'h06) ? 8'h00 : wday + 8'h01;
      end
      if (c_d)  tm_nx[39:32] = c_mo ? 8'h01 : bcd_inc(mon);
      if (c_mo) tm_nx[47:40] = (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
    end else if (wr_time && !run_q) begin
      for (int i = 0; i < NF; i++)
        if (addr == ADDR_W'(i)) tm_nx[8*i +: 8] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q   <= TM_RST;
      sh_q   <= TM_RST;
      run_q  <= 1'b0;
      snap_q <= 1'b0;
      pu_q   <= 1'b1;
    end else begin
      tm_q <= tm_nx;
      if (snap_q) sh_q <= tm_q;
      if (wr_ctrl) begin
        run_q  <= wdata[0];
        snap_q <= wdata[6];
      end else if (snap_q) begin
        snap_q <= 1'b0;
      end
      if (wr_stat && wdata[7]) pu_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NF; i++)
      if (addr == ADDR_W'(i)) rdata = sh_q[8*i +: 8];
    if (addr == CTRL_ADDR) rdata = {1'b0, snap_q, 5'b0, run_q};
    if (addr == STAT_ADDR) rdata = {pu_q, 5'b0, run_q, 1'b0};
  end

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_time) |=> $stable(tm_q));
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && sec == 8'h59) |=> (sec == 8'h00));
  p_snap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_q |=> (sh_q == $past(tm_q)));
  p_snap_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q && !wr_ctrl) |=> !snap_q);
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_q |=> $stable(sh_q));
  p_run_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && wr_time) |=> $stable(tm_q));
  p_pu_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pu_q |=> !pu_q);
endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = 5'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int total = 0, bad = 0;

  bcd_rtc_core dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y, w);
    logic [7:0] v[7];
    v = '{s, m, h, d, mo, y, w};
    wr(5'h0D, 8'h00);
    for (int i = 0; i < 7; i++) wr(5'(i), v[i]);
  endtask

  task automatic snap(input logic run);
    wr(5'h0D, {1'b0, 1'b1, 5'b0, run});
    @(negedge clk);
  endtask

  task automatic expect_time(input string tag, input logic [7:0] s, m, h, d, mo, y, w);
    logic [7:0] v[7];
    logic [7:0] r;
    v = '{s, m, h, d, mo, y, w};
    snap(1'b1);
    for (int i = 0; i < 7; i++) begin
      rd(5'(i), r);
      chk($sformatf("%s field%0d", tag, i), r, v[i]);
    end
  endtask

  task automatic roll(input string tag, input logic [7:0] d, mo, y, w,
                      input logic [7:0] ed, emo, ey, ew);
    set_time(8'h59, 8'h59, 8'h23, d, mo, y, w);
    wr(5'h0D, 8'h01);
    ticks(1);
    expect_time(tag, 8'h00, 8'h00, 8'h00, ed, emo, ey, ew);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    logic [7:0] e[7];
    e = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};
    for (int i = 0; i < 7; i++) begin
      rd(5'(i), r);
      chk($sformatf("R1 reset field%0d", i), r, e[i]);
    end
    rd(5'h0D, r); chk("R1 reset ctrl", r, 8'h00);
    rd(5'h0E, r); chk("R1 reset status", r, 8'h80);
  endtask

  task automatic t_status;
    logic [7:0] r;
    wr(5'h0D, 8'h01);
    rd(5'h0D, r); chk("R10 ctrl run readback", r, 8'h01);
    rd(5'h0E, r); chk("R10 status run bit", r, 8'h82);
    wr(5'h0E, 8'h7F);
    rd(5'h0E, r); chk("R11 flag kept on zero write", r, 8'h82);
    wr(5'h0E, 8'h80);
    rd(5'h0E, r); chk("R11 flag cleared", r, 8'h02);
    wr(5'h0D, 8'h00);
    rd(5'h0E, r); chk("R10 status stopped", r, 8'h00);
  endtask

  task automatic t_bcd_count;
    set_time(8'h08, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    wr(5'h0D, 8'h01);
    ticks(3);
    expect_time("R2 bcd count", 8'h11, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    wr(5'h0D, 8'h00);
    ticks(4);
    snap(1'b0);
    expect_time("R2 stopped ticks", 8'h11, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
  endtask

  task automatic t_carry;
    set_time(8'h59, 8'h59, 8'h00, 8'h07, 8'h05, 8'h30, 8'h02);
    wr(5'h0D, 8'h01);
    ticks(1);
    expect_time("R3 hour carry", 8'h00, 8'h00, 8'h01, 8'h07, 8'h05, 8'h30, 8'h02);
    roll("R3 R7 full chain", 8'h15, 8'h03, 8'h24, 8'h03, 8'h16, 8'h03, 8'h24, 8'h04);
  endtask

  task automatic t_months;
    roll("R4 april end", 8'h30, 8'h04, 8'h21, 8'h00, 8'h01, 8'h05, 8'h21, 8'h01);
    roll("R4 jan 30", 8'h30, 8'h01, 8'h21, 8'h01, 8'h31, 8'h01, 8'h21, 8'h02);
    roll("R4 jan end", 8'h31, 8'h01, 8'h21, 8'h02, 8'h01, 8'h02, 8'h21, 8'h03);
    roll("R4 nov end", 8'h30, 8'h11, 8'h21, 8'h03, 8'h01, 8'h12, 8'h21, 8'h04);
    roll("R4 jul end", 8'h31, 8'h07, 8'h21, 8'h04, 8'h01, 8'h08, 8'h21, 8'h05);
  endtask

  task automatic t_leap;
    roll("R5 common feb", 8'h28, 8'h02, 8'h23, 8'h01, 8'h01, 8'h03, 8'h23, 8'h02);
    roll("R5 leap feb 28", 8'h28, 8'h02, 8'h24, 8'h01, 8'h29, 8'h02, 8'h24, 8'h02);
    roll("R5 leap feb 29", 8'h29, 8'h02, 8'h24, 8'h02, 8'h01, 8'h03, 8'h24, 8'h03);
    roll("R5 year00 feb", 8'h28, 8'h02, 8'h00, 8'h05, 8'h29, 8'h02, 8'h00, 8'h06);
    roll("R5 year10 feb", 8'h28, 8'h02, 8'h10, 8'h05, 8'h01, 8'h03, 8'h10, 8'h06);
  endtask

  task automatic t_year;
    roll("R6 year step", 8'h31, 8'h12, 8'h24, 8'h01, 8'h01, 8'h01, 8'h25, 8'h02);
    roll("R6 century wrap", 8'h31, 8'h12, 8'h99, 8'h04, 8'h01, 8'h01, 8'h00, 8'h05);
  endtask

  task automatic t_wday;
    roll("R7 weekday wrap", 8'h10, 8'h06, 8'h22, 8'h06, 8'h11, 8'h06, 8'h22, 8'h00);
    set_time(8'h58, 8'h59, 8'h23, 8'h10, 8'h06, 8'h22, 8'h06);
    wr(5'h0D, 8'h01);
    ticks(1);
    expect_time("R7 weekday holds", 8'h59, 8'h59, 8'h23, 8'h10, 8'h06, 8'h22, 8'h06);
  endtask

  task automatic t_snap;
    logic [7:0] r;
    set_time(8'h10, 8'h20, 8'h05, 8'h02, 8'h02, 8'h02, 8'h02);
    wr(5'h0D, 8'h01);
    snap(1'b1);
    ticks(5);
    rd(5'h00, r); chk("R8 shadow frozen", r, 8'h10);
    wr(5'h0D, 8'h41);
    rd(5'h0D, r); chk("R8 request bit set", r, 8'h41);
    @(negedge clk);
    rd(5'h0D, r); chk("R8 request bit self clear", r, 8'h01);
    rd(5'h00, r); chk("R8 shadow updated", r, 8'h15);
  endtask

  task automatic t_wr_run;
    wr(5'h00, 8'h42);
    wr(5'h02, 8'h17);
    expect_time("R9 write ignored while running", 8'h15, 8'h20, 8'h05, 8'h02, 8'h02, 8'h02, 8'h02);
    wr(5'h0D, 8'h00);
    wr(5'h00, 8'h42);
    wr(5'h02, 8'h17);
    expect_time("R9 write while stopped", 8'h42, 8'h20, 8'h17, 8'h02, 8'h02, 8'h02, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_status;
    t_bcd_count;
    t_carry;
    t_months;
    t_leap;
    t_year;
    t_wday;
    t_snap;
    t_wr_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule